// File: doc/BRIEF.md
# Effective-to-Physical Address Translation Unit

This unit maps a 32-bit effective address onto a 32-bit physical address. Two translation stores are searched in the same cycle. The first is a small array of block descriptors, compared in full parallel. Each descriptor covers a region whose size is set by a per-entry mask. The second is a two-way set-associative page cache holding 4 KB page translations, with least-recently-used replacement inside each set. When both stores produce a translation, the block descriptor is used.

A lookup is presented for one cycle on the request port. Its result appears on the registered response outputs in the following cycle, as a hit with its physical address or as a one-cycle miss pulse. A miss tells the surrounding logic that a page-table walk is needed. Software fills both stores through separate write ports. The block port writes a chosen slot directly. The page port writes a translation into its set, and the unit picks the way itself.

Top module: `xlat_unit`

## Requirements
- R1: After reset all response outputs are low and every block and page entry is invalid, so the first lookup misses.
- R2: A lookup sampled with `lk_valid` high at a clock edge produces `rsp_valid` high for exactly the next cycle; with `lk_valid` low, `rsp_valid` and `rsp_miss` stay low.
- R3: Bit i of a block entry's 20-bit mask governs effective address bit i+12. The entry matches when all masked bits equal its virtual base. On a match, the masked physical bits come from the entry's physical base and the unmasked bits pass through from the effective address. Bits 11:0 always pass through unchanged.
- R4: When several valid block entries match, the entry with the lowest slot index supplies the translation.
- R5: A block match overrides a simultaneous page-cache hit; `rsp_blk` is then high.
- R6: The page cache uses effective address bits 16:12 as the set index and bits 31:17 as the tag. On a hit the physical address is the stored 20-bit page number followed by the 12-bit offset, with `rsp_blk` low.
- R7: A lookup that matches neither store raises `rsp_miss` for one cycle, with `rsp_hit` low and `rsp_pa` zero.
- R8: A page write whose tag is already valid in its set overwrites that way. Otherwise it fills the set's least-recently-used way. The written way becomes most recently used, and no set ever holds two valid ways with the same tag.
- R9: A lookup whose translation comes from the page cache makes the hit way most recently used. A page-cache hit that a block match overrides leaves the replacement order unchanged.
- R10: A block write with `blk_wr_valid` low invalidates the slot, and an invalid slot never matches.
- R11: Writes take effect at the clock edge. A lookup in the same cycle as a write sees the previous contents, and lookups from the next cycle see the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_ea | input | 32 | Effective address to translate |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_hit | output | 1 | Translation found |
| rsp_blk | output | 1 | Translation came from a block entry |
| rsp_miss | output | 1 | Both stores missed; walk needed |
| rsp_pa | output | 32 | Physical address (zero on miss) |
| blk_wr_en | input | 1 | Block entry write strobe |
| blk_wr_idx | input | 2 | Block slot to write |
| blk_wr_valid | input | 1 | Valid bit written into the slot |
| blk_wr_vbase | input | 20 | Virtual base (address bits 31:12) |
| blk_wr_pbase | input | 20 | Physical base (address bits 31:12) |
| blk_wr_mask | input | 20 | Compare/translate mask, bit i for address bit i+12 |
| tlb_wr_en | input | 1 | Page translation write strobe |
| tlb_wr_vpn | input | 20 | Virtual page number (address bits 31:12) |
| tlb_wr_ppn | input | 20 | Physical page number |

## Verification
The embedded properties watch, on every cycle, the response timing, the mutual exclusion of hit and miss, the zero address on a miss and the passthrough of the page offset. They also check that a block hit reports a hit, that invalidated slots stop matching, that no set holds a duplicate tag, and that the replacement bit follows each used way. The directed scenarios cover what depends on the stored values. This includes the translated addresses under different mask widths, the lowest-slot priority and the override of a page hit by a block hit. It also includes the eviction order after refreshes and after overshadowed hits, in-place rewrites of an existing tag, and the one-cycle lag between a write and its visibility.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
   // Which store produced the current lookup's translation
   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_BLK  = 2'd1,
      SRC_TLB  = 2'd2
   } xl_src_e;
endpackage

// File: rtl/xlat_blk_array.sv
module xlat_blk_array #(
   parameter int VPN_W = 20,
   parameter int NENT  = 4,
   localparam int IDX_W = (NENT > 1) ? $clog2(NENT) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_valid,
   input  logic [VPN_W-1:0] wr_vbase,
   input  logic [VPN_W-1:0] wr_pbase,
   input  logic [VPN_W-1:0] wr_mask,
   input  logic [VPN_W-1:0] lk_vpn,
   output logic             hit,
   output logic [VPN_W-1:0] out_vpn
);
   logic [NENT-1:0]  ent_v;
   logic [VPN_W-1:0] ent_vb [NENT];
   logic [VPN_W-1:0] ent_pb [NENT];
   logic [VPN_W-1:0] ent_mk [NENT];
   logic [NENT-1:0]  match;
   logic [NENT-1:0]  grant;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_v <= '0;
      else if (wr_en) ent_v[wr_idx] <= wr_valid;
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         ent_vb[wr_idx] <= wr_vbase;
         ent_pb[wr_idx] <= wr_pbase;
         ent_mk[wr_idx] <= wr_mask;
      end
   end

   // all slots compared side by side
   for (genvar i = 0; i < NENT; i++) begin : g_cmp
      assign match[i] = ent_v[i] && (((lk_vpn ^ ent_vb[i]) & ent_mk[i]) == '0);

      // R10: a slot written invalid no longer matches
      p_inval_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && !wr_valid && wr_idx == IDX_W'(i)) |=> !match[i]);
   end

   // lowest index wins
   assign grant = match & (~match + NENT'(1));
   assign hit   = |match;

   always_comb begin
      out_vpn = '0;
      for (int i = 0; i < NENT; i++) begin
         if (grant[i]) out_vpn = (ent_pb[i] & ent_mk[i]) | (lk_vpn & ~ent_mk[i]);
      end
   end
endmodule

// File: rtl/xlat_lru.sv
module xlat_lru #(
   parameter int SETS = 32,
   localparam int SET_W = $clog2(SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             use_en,
   input  logic [SET_W-1:0] use_set,
   input  logic             use_way,
   input  logic             wr_en,
   input  logic [SET_W-1:0] wr_set,
   input  logic             wr_way,
   output logic             victim
);
   // one bit per set: the way to replace next
   logic [SETS-1:0] lru_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lru_q <= '0;
      else begin
         for (int s = 0; s < SETS; s++) begin
            if (wr_en && wr_set == SET_W'(s))        lru_q[s] <= ~wr_way;
            else if (use_en && use_set == SET_W'(s)) lru_q[s] <= ~use_way;
         end
      end
   end

   assign victim = lru_q[wr_set];

   // R9: a used way becomes most recent (write has precedence on the same set)
   p_lru_use_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (use_en && !(wr_en && wr_set == use_set)) |=> (lru_q[$past(use_set)] == !$past(use_way)));

   // R8: a written way becomes most recent
   p_lru_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (lru_q[$past(wr_set)] == !$past(wr_way)));
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb #(
   parameter int VPN_W = 20,
   parameter int SETS  = 32,
   localparam int SET_W = $clog2(SETS),
   localparam int TAG_W = VPN_W - SET_W,
   localparam int WAYS  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [VPN_W-1:0] lk_vpn,
   output logic             hit,
   output logic             hit_way,
   output logic [VPN_W-1:0] ppn,
   input  logic             wr_en,
   input  logic [VPN_W-1:0] wr_vpn,
   input  logic [VPN_W-1:0] wr_ppn,
   input  logic             victim,
   output logic [SET_W-1:0] wr_set,
   output logic             wr_way
);
   logic [WAYS-1:0]  val_q [SETS];
   logic [TAG_W-1:0] tag_q [SETS][WAYS];
   logic [VPN_W-1:0] ppn_q [SETS][WAYS];

   logic [SET_W-1:0] lk_set;
   logic [TAG_W-1:0] lk_tag, wr_tag;
   logic [WAYS-1:0]  way_hit, wr_match;

   assign lk_set = lk_vpn[SET_W-1:0];
   assign lk_tag = lk_vpn[VPN_W-1:SET_W];
   assign wr_set = wr_vpn[SET_W-1:0];
   assign wr_tag = wr_vpn[VPN_W-1:SET_W];

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign way_hit[w]  = val_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
      assign wr_match[w] = val_q[wr_set][w] && (tag_q[wr_set][w] == wr_tag);
   end

   assign hit     = |way_hit;
   assign hit_way = way_hit[1];
   assign ppn     = way_hit[1] ? ppn_q[lk_set][1] : ppn_q[lk_set][0];

   // reuse a way holding the same tag, else take the LRU way
   assign wr_way = wr_match[0] ? 1'b0 : (wr_match[1] ? 1'b1 : victim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) val_q[s] <= '0;
      end else if (wr_en) begin
         val_q[wr_set][wr_way] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_set][wr_way] <= wr_tag;
         ppn_q[wr_set][wr_way] <= wr_ppn;
      end
   end

   // R8: never two live copies of one tag in a set
   for (genvar s = 0; s < SETS; s++) begin : g_chk
      p_no_dup_r8: assert property (@(posedge clk) disable iff (!rst_n)
         !(val_q[s] == 2'b11 && tag_q[s][0] == tag_q[s][1]));
   end
endmodule

// File: rtl/xlat_unit.sv
module xlat_unit #(
   parameter int EA_W     = 32,
   parameter int PG_BITS  = 12,
   parameter int BLK_N    = 4,
   parameter int TLB_SETS = 32,
   localparam int VPN_W   = EA_W - PG_BITS,
   localparam int SET_W   = $clog2(TLB_SETS),
   localparam int BIDX_W  = (BLK_N > 1) ? $clog2(BLK_N) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [EA_W-1:0]   lk_ea,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic              rsp_blk,
   output logic              rsp_miss,
   output logic [EA_W-1:0]   rsp_pa,
   input  logic              blk_wr_en,
   input  logic [BIDX_W-1:0] blk_wr_idx,
   input  logic              blk_wr_valid,
   input  logic [VPN_W-1:0]  blk_wr_vbase,
   input  logic [VPN_W-1:0]  blk_wr_pbase,
   input  logic [VPN_W-1:0]  blk_wr_mask,
   input  logic              tlb_wr_en,
   input  logic [VPN_W-1:0]  tlb_wr_vpn,
   input  logic [VPN_W-1:0]  tlb_wr_ppn
);
   import xlat_pkg::*;

   initial begin
      a_widths: assert (EA_W > PG_BITS && PG_BITS > 0) else $error("page offset must fit in the address");
      a_sets: assert (TLB_SETS >= 2 && (TLB_SETS & (TLB_SETS - 1)) == 0) else $error("set count must be a power of two");
      a_tag: assert (SET_W < VPN_W) else $error("no tag bits left");
      a_blk: assert (BLK_N >= 1) else $error("need at least one block slot");
   end

   logic [VPN_W-1:0]   lk_vpn;
   logic               blk_hit, tlb_hit, tlb_way, victim, wr_way;
   logic [VPN_W-1:0]   blk_vpn, tlb_ppn;
   logic [SET_W-1:0]   wr_set;
   xl_src_e            src;
   logic [VPN_W-1:0]   sel_vpn;

   assign lk_vpn = lk_ea[EA_W-1:PG_BITS];

   xlat_blk_array #(.VPN_W(VPN_W), .NENT(BLK_N)) u_blk (
      .clk(clk), .rst_n(rst_n),
      .wr_en(blk_wr_en), .wr_idx(blk_wr_idx), .wr_valid(blk_wr_valid),
      .wr_vbase(blk_wr_vbase), .wr_pbase(blk_wr_pbase), .wr_mask(blk_wr_mask),
      .lk_vpn(lk_vpn), .hit(blk_hit), .out_vpn(blk_vpn)
   );

   xlat_tlb #(.VPN_W(VPN_W), .SETS(TLB_SETS)) u_tlb (
      .clk(clk), .rst_n(rst_n),
      .lk_vpn(lk_vpn), .hit(tlb_hit), .hit_way(tlb_way), .ppn(tlb_ppn),
      .wr_en(tlb_wr_en), .wr_vpn(tlb_wr_vpn), .wr_ppn(tlb_wr_ppn),
      .victim(victim), .wr_set(wr_set), .wr_way(wr_way)
   );

   xlat_lru #(.SETS(TLB_SETS)) u_lru (
      .clk(clk), .rst_n(rst_n),
      .use_en(lk_valid && src == SRC_TLB), .use_set(lk_vpn[SET_W-1:0]), .use_way(tlb_way),
      .wr_en(tlb_wr_en), .wr_set(wr_set), .wr_way(wr_way),
      .victim(victim)
   );

   // block translation outranks the page cache
   always_comb begin
      if (blk_hit)      src = SRC_BLK;
      else if (tlb_hit) src = SRC_TLB;
      else              src = SRC_NONE;
      sel_vpn = (src == SRC_BLK) ? blk_vpn : tlb_ppn;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_blk   <= 1'b0;
         rsp_miss  <= 1'b0;
         rsp_pa    <= '0;
      end else begin
         rsp_valid <= lk_valid;
         rsp_hit   <= lk_valid && src != SRC_NONE;
         rsp_blk   <= lk_valid && src == SRC_BLK;
         rsp_miss  <= lk_valid && src == SRC_NONE;
         rsp_pa    <= (lk_valid && src != SRC_NONE) ? {sel_vpn, lk_ea[PG_BITS-1:0]} : '0;
      end
   end

   // R2: response follows request by one cycle
   p_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> rsp_valid);
   p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> (!rsp_valid && !rsp_miss));
   // R7: a miss carries no address and no hit
   p_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_miss |-> (!rsp_hit && rsp_pa == '0));
   p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_hit ^ rsp_miss));
   // R3: page offset passes straight through
   p_offset_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> (rsp_pa[PG_BITS-1:0] == $past(lk_ea[PG_BITS-1:0])));
   // R5: block source implies a hit
   p_blk_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_blk |-> rsp_hit);
endmodule

// File: tb/test_xlat_unit.sv
`timescale 1ns/1ps
module test_xlat_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_ea = '0;
   logic        rsp_valid, rsp_hit, rsp_blk, rsp_miss;
   logic [31:0] rsp_pa;
   logic        blk_wr_en = 1'b0;
   logic [1:0]  blk_wr_idx = '0;
   logic        blk_wr_valid = 1'b0;
   logic [19:0] blk_wr_vbase = '0, blk_wr_pbase = '0, blk_wr_mask = '0;
   logic        tlb_wr_en = 1'b0;
   logic [19:0] tlb_wr_vpn = '0, tlb_wr_ppn = '0;

   int n_chk = 0;
   int n_fail = 0;
   int cycles = 0;

   always #2.5 clk = ~clk;

   xlat_unit i_xlat_unit (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_ea(lk_ea),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_blk(rsp_blk),
      .rsp_miss(rsp_miss), .rsp_pa(rsp_pa),
      .blk_wr_en(blk_wr_en), .blk_wr_idx(blk_wr_idx), .blk_wr_valid(blk_wr_valid),
      .blk_wr_vbase(blk_wr_vbase), .blk_wr_pbase(blk_wr_pbase), .blk_wr_mask(blk_wr_mask),
      .tlb_wr_en(tlb_wr_en), .tlb_wr_vpn(tlb_wr_vpn), .tlb_wr_ppn(tlb_wr_ppn)
   );

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run hung, got %0d cycles exp under 20000", cycles);
         finish_run();
      end
   end

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h exp %h", req, got, exp);
      end
   endtask

   // all tasks start and end just after a falling edge
   task automatic blk_write(input logic [1:0] idx, input logic v,
                            input logic [19:0] vb, input logic [19:0] pb, input logic [19:0] mk);
      blk_wr_en = 1'b1; blk_wr_idx = idx; blk_wr_valid = v;
      blk_wr_vbase = vb; blk_wr_pbase = pb; blk_wr_mask = mk;
      @(posedge clk); @(negedge clk);
      blk_wr_en = 1'b0;
   endtask

   task automatic tlb_write(input logic [19:0] vpn, input logic [19:0] ppn);
      tlb_wr_en = 1'b1; tlb_wr_vpn = vpn; tlb_wr_ppn = ppn;
      @(posedge clk); @(negedge clk);
      tlb_wr_en = 1'b0;
   endtask

   task automatic look(input logic [31:0] ea);
      lk_valid = 1'b1; lk_ea = ea;
      @(posedge clk); @(negedge clk);
      lk_valid = 1'b0;
   endtask

   task automatic expect_hit(input string req, input logic [31:0] ea,
                             input logic [31:0] pa, input logic blk);
      look(ea);
      chk(req, {28'd0, rsp_valid, rsp_hit, rsp_blk, rsp_miss}, {28'd0, 1'b1, 1'b1, blk, 1'b0});
      chk(req, rsp_pa, pa);
   endtask

   task automatic expect_miss(input string req, input logic [31:0] ea);
      look(ea);
      chk(req, {28'd0, rsp_valid, rsp_hit, rsp_blk, rsp_miss}, 32'h0000_0009);
      chk(req, rsp_pa, 32'h0);
   endtask

   task automatic t_reset();
      chk("R1 reset outputs", {28'd0, rsp_valid, rsp_hit, rsp_blk, rsp_miss}, 32'h0);
      chk("R1 reset pa", rsp_pa, 32'h0);
      expect_miss("R1 R7 empty stores miss", 32'h1234_5678);
      @(posedge clk); @(negedge clk);
      chk("R7 R2 miss lasts one cycle", {30'd0, rsp_valid, rsp_miss}, 32'h0);
   endtask

   task automatic t_tlb_basic();
      tlb_write(20'h12345, 20'hABCDE);
      expect_hit("R6 page hit", 32'h1234_5678, 32'hABCD_E678, 1'b0);
   endtask

   task automatic t_blk_basic();
      // 1 MB block: mask covers address bits 31:20
      blk_write(2'd1, 1'b1, 20'h80000, 20'h00100, 20'hFFF00);
      expect_hit("R3 block 1MB translate", 32'h800A_4321, 32'h001A_4321, 1'b1);
      expect_miss("R3 outside block", 32'h8010_0000);
      // single-page block
      blk_write(2'd2, 1'b1, 20'h40000, 20'h77777, 20'hFFFFF);
      expect_hit("R3 block 4KB translate", 32'h4000_0ABC, 32'h7777_7ABC, 1'b1);
      expect_miss("R3 neighbour page outside", 32'h4000_1ABC);
   endtask

   task automatic t_priority();
      blk_write(2'd0, 1'b1, 20'h80000, 20'h30000, 20'hF0000);
      expect_hit("R4 lowest slot wins", 32'h800A_4321, 32'h300A_4321, 1'b1);
   endtask

   task automatic t_override();
      tlb_write(20'h800A4, 20'h11111);
      expect_hit("R5 block beats page", 32'h800A_4321, 32'h300A_4321, 1'b1);
      blk_write(2'd0, 1'b0, 20'h80000, 20'h30000, 20'hF0000);
      blk_write(2'd1, 1'b0, 20'h80000, 20'h00100, 20'hFFF00);
      expect_hit("R10 invalidated slots skipped", 32'h800A_4321, 32'h1111_1321, 1'b0);
   endtask

   task automatic t_same_cycle();
      tlb_wr_en = 1'b1; tlb_wr_vpn = 20'h55555; tlb_wr_ppn = 20'h66666;
      lk_valid = 1'b1; lk_ea = 32'h5555_5000;
      @(posedge clk); @(negedge clk);
      tlb_wr_en = 1'b0; lk_valid = 1'b0;
      chk("R11 same-cycle lookup sees old", {31'd0, rsp_miss}, 32'h1);
      expect_hit("R11 visible next cycle", 32'h5555_5000, 32'h6666_6000, 1'b0);
   endtask

   task automatic t_lru_refresh();
      // set 3: A=00003 B=00023 C=00043
      tlb_write(20'h00003, 20'h0A000);
      tlb_write(20'h00023, 20'h0B000);
      expect_hit("R9 A hit", 32'h0000_3010, 32'h0A00_0010, 1'b0);
      tlb_write(20'h00043, 20'h0C000);
      expect_miss("R8 R9 B evicted", 32'h0002_3010);
      expect_hit("R8 C filled", 32'h0004_3020, 32'h0C00_0020, 1'b0);
      expect_hit("R9 A survived", 32'h0000_3030, 32'h0A00_0030, 1'b0);
   endtask

   task automatic t_rewrite();
      // A most recent, C is the victim; rewriting A must stay in A's way
      tlb_write(20'h00003, 20'h0AAAA);
      expect_hit("R8 C kept on rewrite", 32'h0004_3040, 32'h0C00_0040, 1'b0);
      expect_hit("R8 A rewritten", 32'h0000_3050, 32'h0AAA_A050, 1'b0);
   endtask

   task automatic t_shadow_no_refresh();
      // set 7: D=00007 E=00027 F=00047
      tlb_write(20'h00007, 20'h0D000);
      tlb_write(20'h00027, 20'h0E000);
      blk_write(2'd3, 1'b1, 20'h00007, 20'h99999, 20'hFFFFF);
      expect_hit("R5 block covers D", 32'h0000_7123, 32'h9999_9123, 1'b1);
      tlb_write(20'h00047, 20'h0F000);
      blk_write(2'd3, 1'b0, 20'h00007, 20'h99999, 20'hFFFFF);
      expect_miss("R9 shadowed hit did not refresh D", 32'h0000_7123);
      expect_hit("R9 E kept", 32'h0002_7123, 32'h0E00_0123, 1'b0);
      expect_hit("R8 F filled", 32'h0004_7123, 32'h0F00_0123, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_tlb_basic();
      t_blk_basic();
      t_priority();
      t_override();
      t_same_cycle();
      t_lru_refresh();
      t_rewrite();
      t_shadow_no_refresh();
      @(negedge clk);
      finish_run();
   end
endmodule